// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Tag Wakeup and Age-Ordered Select

This block holds renamed instructions between decode and execution in an out-of-order pipeline. Each arriving instruction brings two source physical tags, a flag per source that says whether the value already exists, and an opaque payload. The queue watches the writeback tag broadcasts. When a broadcast tag matches a source tag held in the queue, that operand becomes ready.

Every cycle, an arbiter looks at the entries whose two operands are both ready. It sends up to a fixed number of them to the functional units, oldest first. Age is the order of insertion, not the slot index. The queue is sized separately from the reorder buffer and is smaller than it. When every slot is taken, the queue raises a stall signal toward decode. A flush empties the queue in one cycle.

Top module: `issue_window`

## Requirements
- R1: After reset, `full` is low and every `iss_valid` bit is low. An empty queue issues nothing.
- R2: An instruction is written when `in_valid` is high and `full` is low. `full` is high exactly when all ENTRIES slots hold an instruction. An `in_valid` while `full` is high is dropped.
- R3: Each source's readiness at insertion comes from its bit of `in_rdy`. Bit s belongs to the tag in bits [s*TAG_W +: TAG_W] of `in_tag`.
- R4: A writeback on any lane j (`wb_valid[j]`, tag in bits [j*TAG_W +: TAG_W] of `wb_tag`) marks ready every held source whose tag equals it. The entry can issue from the next cycle on. A non-matching tag changes nothing.
- R5: If an instruction is inserted in the same cycle as a broadcast of one of its source tags, that source is recorded as ready.
- R6: An entry may issue only when both of its sources are ready.
- R7: Up to ISS_W entries issue per cycle. Lane 0 carries the oldest eligible entry, and lane k carries the next oldest after lane k-1, judged by insertion order whatever the slot.
- R8: Issue outputs are combinational from the held state. An entry inserted, or woken, at a clock edge is visible on the issue lanes after that edge.
- R9: An issued entry leaves the queue at the next clock edge and is never issued twice.
- R10: `flush` empties the queue at the next edge, and takes priority over an insertion in the same cycle.
- R11: `iss_payload` lane k carries the payload written with the instruction, unchanged, in bits [k*PAY_W +: PAY_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all held instructions |
| in_valid | input | 1 | Decode presents an instruction |
| in_tag | input | 2*TAG_W | Source physical tags |
| in_rdy | input | 2 | Source already-ready flags |
| in_payload | input | PAY_W | Opaque instruction payload |
| full | output | 1 | No free slot; decode must stall |
| wb_valid | input | WB_W | Writeback broadcast valid per lane |
| wb_tag | input | WB_W*TAG_W | Writeback destination tags |
| iss_valid | output | ISS_W | Issue lane carries an instruction |
| iss_payload | output | ISS_W*PAY_W | Payload per issue lane |

## Verification
The bench builds the queue with its defaults: 8 entries, 6-bit tags, 16-bit payloads, two issue lanes and two writeback lanes. With only 8 slots, filling the queue and pressing on it while full takes a few cycles. Two issue lanes are enough to show how eligible entries are ordered across lanes. The age test reuses a freed low slot for a young instruction, so a picker that ranks by slot index would issue in the wrong order.

// File: rtl/iw_pkg.sv
package iw_pkg;

    parameter int IW_TAG_W = 6;
    parameter int IW_NSRC  = 2;

    typedef struct packed {
        logic [IW_TAG_W-1:0] tag;
        logic                rdy;
    } opnd_t;

    // true when sequence number a was handed out before b (wrap-safe)
    function automatic logic seq_before(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input int          w);
        logic [31:0] d;
        d = a - b;
        return d[w-1];
    endfunction

endpackage

// File: rtl/iw_alloc.sv
module iw_alloc #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] occ,
    output logic               any_free,
    output logic [IDX_W-1:0]   free_idx
);
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/iw_wakeup.sv
module iw_wakeup
    import iw_pkg::*;
#(
    parameter int N    = 8,
    parameter int WB_W = 2
) (
    input  opnd_t [N-1:0][IW_NSRC-1:0]   opnd,
    input  logic  [WB_W-1:0]             wb_valid,
    input  logic  [WB_W-1:0][IW_TAG_W-1:0] wb_tag,
    output logic  [N-1:0][IW_NSRC-1:0]   hit
);
    for (genvar e = 0; e < N; e++) begin : g_ent
        for (genvar s = 0; s < IW_NSRC; s++) begin : g_src
            always_comb begin
                hit[e][s] = 1'b0;
                for (int j = 0; j < WB_W; j++) begin
                    if (wb_valid[j] && wb_tag[j] == opnd[e][s].tag) begin
                        hit[e][s] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/iw_select.sv
module iw_select
    import iw_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ISS_W   = 2,
    parameter int SEQ_W   = 4,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            req,
    input  logic [ENTRIES-1:0][SEQ_W-1:0] seq,
    output logic [ISS_W-1:0]              gnt_valid,
    output logic [ISS_W-1:0][IDX_W-1:0]   gnt_idx,
    output logic [ENTRIES-1:0]            gnt_mask
);
    always_comb begin
        logic [ENTRIES-1:0] avail;
        logic               found;
        logic [IDX_W-1:0]   best;
        avail     = req;
        gnt_valid = '0;
        gnt_idx   = '0;
        gnt_mask  = '0;
        for (int k = 0; k < ISS_W; k++) begin
            found = 1'b0;
            best  = '0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (avail[i] && (!found ||
                    seq_before(32'(seq[i]), 32'(seq[best]), SEQ_W))) begin
                    found = 1'b1;
                    best  = IDX_W'(i);
                end
            end
            gnt_valid[k] = found;
            gnt_idx[k]   = best;
            if (found) begin
                avail[best]    = 1'b0;
                gnt_mask[best] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/issue_window.sv
module issue_window
    import iw_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PAY_W   = 16,
    parameter int ISS_W   = 2,
    parameter int WB_W    = 2,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int SEQ_W  = IDX_W + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          in_valid,
    input  logic [IW_NSRC*IW_TAG_W-1:0]   in_tag,
    input  logic [IW_NSRC-1:0]            in_rdy,
    input  logic [PAY_W-1:0]              in_payload,
    output logic                          full,
    input  logic [WB_W-1:0]               wb_valid,
    input  logic [WB_W*IW_TAG_W-1:0]      wb_tag,
    output logic [ISS_W-1:0]              iss_valid,
    output logic [ISS_W*PAY_W-1:0]        iss_payload
);
    logic  [ENTRIES-1:0]                 valid_q;
    opnd_t [ENTRIES-1:0][IW_NSRC-1:0]    opnd_q;
    logic  [ENTRIES-1:0][SEQ_W-1:0]      seq_q;
    logic  [ENTRIES-1:0][PAY_W-1:0]      pay_q;
    logic  [SEQ_W-1:0]                   seq_ctr;

    logic                                any_free;
    logic  [IDX_W-1:0]                   alloc_idx;
    logic  [ENTRIES-1:0][IW_NSRC-1:0]    wk_hit;
    opnd_t [0:0][IW_NSRC-1:0]            in_opnd;
    logic  [0:0][IW_NSRC-1:0]            in_hit;
    logic  [ENTRIES-1:0]                 req;
    logic  [ISS_W-1:0]                   gnt_valid;
    logic  [ISS_W-1:0][IDX_W-1:0]        gnt_idx;
    logic  [ENTRIES-1:0]                 gnt_mask;
    logic                                ins_fire;

    always_comb begin
        for (int s = 0; s < IW_NSRC; s++) begin
            in_opnd[0][s].tag = in_tag[s*IW_TAG_W +: IW_TAG_W];
            in_opnd[0][s].rdy = in_rdy[s];
        end
    end

    iw_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .occ(valid_q), .any_free(any_free), .free_idx(alloc_idx)
    );

    iw_wakeup #(.N(ENTRIES), .WB_W(WB_W)) u_wake_held (
        .opnd(opnd_q), .wb_valid(wb_valid), .wb_tag(wb_tag), .hit(wk_hit)
    );

    iw_wakeup #(.N(1), .WB_W(WB_W)) u_wake_new (
        .opnd(in_opnd), .wb_valid(wb_valid), .wb_tag(wb_tag), .hit(in_hit)
    );

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            req[i] = valid_q[i];
            for (int s = 0; s < IW_NSRC; s++) begin
                req[i] = req[i] & opnd_q[i][s].rdy;
            end
        end
    end

    iw_select #(.ENTRIES(ENTRIES), .ISS_W(ISS_W), .SEQ_W(SEQ_W)) u_sel (
        .req(req), .seq(seq_q),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_mask(gnt_mask)
    );

    assign full     = ~any_free;
    assign ins_fire = in_valid & any_free & ~flush;

    always_comb begin
        for (int k = 0; k < ISS_W; k++) begin
            iss_valid[k]                  = gnt_valid[k];
            iss_payload[k*PAY_W +: PAY_W] = pay_q[gnt_idx[k]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            opnd_q  <= '0;
            seq_q   <= '0;
            pay_q   <= '0;
            seq_ctr <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                for (int s = 0; s < IW_NSRC; s++) begin
                    if (wk_hit[i][s]) opnd_q[i][s].rdy <= 1'b1;
                end
                if (gnt_mask[i]) valid_q[i] <= 1'b0;
                if (ins_fire && alloc_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    seq_q[i]   <= seq_ctr;
                    pay_q[i]   <= in_payload;
                    for (int s = 0; s < IW_NSRC; s++) begin
                        opnd_q[i][s].tag <= in_opnd[0][s].tag;
                        opnd_q[i][s].rdy <= in_opnd[0][s].rdy | in_hit[0][s];
                    end
                end
            end
            if (ins_fire) seq_ctr <= seq_ctr + 1'b1;
        end
    end

    // ---------------- assertions ----------------
    p_empty_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (valid_q == '0) |-> (iss_valid == '0));

    p_full_no_new_r2: assert property (@(posedge clk) disable iff (rst)
        full |=> ((valid_q & ~$past(valid_q)) == '0));

    p_flush_empty_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    for (genvar i = 0; i < ENTRIES; i++) begin : g_chk_ent
        p_issued_freed_r9: assert property (@(posedge clk) disable iff (rst)
            gnt_mask[i] |=> !valid_q[i]);
        for (genvar s = 0; s < IW_NSRC; s++) begin : g_chk_src
            p_wake_sets_r4: assert property (@(posedge clk) disable iff (rst)
                (valid_q[i] && wk_hit[i][s] && !flush) |=> opnd_q[i][s].rdy);
        end
    end

    for (genvar k = 0; k < ISS_W; k++) begin : g_chk_lane
        p_issue_ready_r6: assert property (@(posedge clk) disable iff (rst)
            gnt_valid[k] |-> (valid_q[gnt_idx[k]] &&
                              opnd_q[gnt_idx[k]][0].rdy &&
                              opnd_q[gnt_idx[k]][1].rdy));
        if (k > 0) begin : g_ord
            p_lane_order_r7: assert property (@(posedge clk) disable iff (rst)
                gnt_valid[k] |-> (gnt_valid[k-1] &&
                    seq_before(32'(seq_q[gnt_idx[k-1]]),
                               32'(seq_q[gnt_idx[k]]), SEQ_W)));
        end
    end

endmodule

// File: tb/test_issue_window.sv
module test_issue_window;
    localparam int TAG_W = 6;
    localparam int PAY_W = 16;
    localparam int ISS_W = 2;
    localparam int WB_W  = 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 flush = 1'b0;
    logic                 in_valid = 1'b0;
    logic [2*TAG_W-1:0]   in_tag = '0;
    logic [1:0]           in_rdy = '0;
    logic [PAY_W-1:0]     in_payload = '0;
    logic                 full;
    logic [WB_W-1:0]      wb_valid = '0;
    logic [WB_W*TAG_W-1:0] wb_tag = '0;
    logic [ISS_W-1:0]     iss_valid;
    logic [ISS_W*PAY_W-1:0] iss_payload;

    int n_run = 0;
    int n_fail = 0;

    issue_window i_issue_window (
        .clk(clk), .rst(rst), .flush(flush),
        .in_valid(in_valid), .in_tag(in_tag), .in_rdy(in_rdy),
        .in_payload(in_payload), .full(full),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .iss_valid(iss_valid), .iss_payload(iss_payload)
    );

    always #4 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        wb_valid = '0;
        flush    = 1'b0;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_lane(input int k, input bit exp_v, input int exp_p,
                              input string req);
        check(iss_valid[k] == exp_v, req, $sformatf("lane%0d valid", k),
              int'(iss_valid[k]), int'(exp_v));
        if (exp_v)
            check(iss_payload[k*PAY_W +: PAY_W] == PAY_W'(exp_p), req,
                  $sformatf("lane%0d payload", k),
                  int'(iss_payload[k*PAY_W +: PAY_W]), exp_p);
    endtask

    task automatic set_ins(input int pay, input int t0, input bit r0,
                           input int t1, input bit r1);
        in_valid   = 1'b1;
        in_payload = PAY_W'(pay);
        in_tag     = {TAG_W'(t1), TAG_W'(t0)};
        in_rdy     = {r1, r0};
    endtask

    task automatic set_wb(input int lane, input int t);
        wb_valid[lane] = 1'b1;
        wb_tag[lane*TAG_W +: TAG_W] = TAG_W'(t);
    endtask

    task automatic ins(input int pay, input int t0, input bit r0,
                       input int t1, input bit r1);
        set_ins(pay, t0, r0, t1, r1);
        tick();
    endtask

    task automatic t_reset();
        check(full == 1'b0, "R1", "full after reset", int'(full), 0);
        check(iss_valid == '0, "R1", "issue after reset", int'(iss_valid), 0);
    endtask

    task automatic t_ready_insert();
        ins(16'hA5A5, 1, 1, 2, 1);
        check_lane(0, 1, 16'hA5A5, "R11");   // R3, R8: ready at insert, visible next
        check_lane(1, 0, 0, "R3");
        tick();
        check_lane(0, 0, 0, "R9");
    endtask

    task automatic t_wakeup();
        ins(16'h0011, 5, 0, 6, 1);
        check_lane(0, 0, 0, "R6");
        set_wb(0, 7); tick();
        check_lane(0, 0, 0, "R4");           // non-matching tag
        set_wb(1, 5); tick();
        check_lane(0, 1, 16'h0011, "R4");
        tick();
        check_lane(0, 0, 0, "R9");
    endtask

    task automatic t_both_sources();
        ins(16'h0040, 40, 0, 41, 0);
        set_wb(0, 40); tick();
        check_lane(0, 0, 0, "R6");           // one of two ready
        set_wb(1, 41); tick();
        check_lane(0, 1, 16'h0040, "R6");
        tick();
        ins(16'h0042, 42, 0, 43, 0);
        set_wb(0, 42); set_wb(1, 43); tick();
        check_lane(0, 1, 16'h0042, "R4");    // two lanes in one cycle
        tick();
    endtask

    task automatic t_same_cycle();
        set_ins(16'h0022, 9, 0, 3, 1);
        set_wb(0, 9);
        tick();
        check_lane(0, 1, 16'h0022, "R5");
        tick();
        check_lane(0, 0, 0, "R9");
    endtask

    task automatic t_age();
        ins(16'h0100, 30, 0, 0, 1);          // slot0
        ins(16'h0101, 31, 0, 0, 1);          // slot1
        ins(16'h0102, 31, 0, 0, 1);          // slot2
        set_wb(0, 30); tick();
        check_lane(0, 1, 16'h0100, "R7");
        check_lane(1, 0, 0, "R7");
        tick();                              // slot0 freed
        ins(16'h0103, 31, 0, 0, 1);          // youngest, lands in slot0
        set_wb(1, 31); tick();
        check_lane(0, 1, 16'h0101, "R7");
        check_lane(1, 1, 16'h0102, "R7");
        tick();
        check_lane(0, 1, 16'h0103, "R7");
        check_lane(1, 0, 0, "R9");
        tick();
        check_lane(0, 0, 0, "R9");
    endtask

    task automatic t_full();
        for (int i = 0; i < 8; i++) begin
            check(full == 1'b0, "R2", "full before last", int'(full), 0);
            ins(16'h0200 + i, 50, 0, 0, 1);
        end
        check(full == 1'b1, "R2", "full with 8 held", int'(full), 1);
        ins(16'h02FF, 50, 1, 0, 1);          // dropped
        check(full == 1'b1, "R2", "full after drop", int'(full), 1);
        check_lane(0, 0, 0, "R2");
        set_wb(0, 50); tick();
        for (int c = 0; c < 4; c++) begin
            check_lane(0, 1, 16'h0200 + 2*c, "R7");
            check_lane(1, 1, 16'h0201 + 2*c, "R7");
            tick();
            check(full == 1'b0, "R2", "full after issue", int'(full), 0);
        end
        check_lane(0, 0, 0, "R2");           // dropped entry never appears
    endtask

    task automatic t_flush();
        ins(16'h0300, 60, 0, 0, 1);
        ins(16'h0301, 60, 0, 0, 1);
        set_ins(16'h0302, 1, 1, 1, 1);       // insert in flush cycle
        flush = 1'b1;
        tick();
        check(full == 1'b0, "R10", "full after flush", int'(full), 0);
        check_lane(0, 0, 0, "R10");
        set_wb(0, 60); tick();
        check_lane(0, 0, 0, "R10");
        check_lane(1, 0, 0, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ready_insert();
        t_wakeup();
        t_both_sources();
        t_same_cycle();
        t_age();
        t_full();
        t_flush();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule